// File: doc/BRIEF.md
# Product-Term Logic Block with Parallel and Shared Expanders

This block is one logic array block of a product-term programmable device. It holds sixteen macrocells. Each macrocell builds five AND terms from any true or complemented choice of 36 array inputs and 16 shared-pool signals. It ORs the terms it keeps into a sum, which then passes through an optional register. A function wider than five terms is built in two ways. The first is to chain neighbouring macrocells so that they hand their whole term set down to a lower-numbered neighbour. The second is to invert one term of a macrocell into a shared pool that every macrocell of the block may read, which gives a sum term by De Morgan's law.

All programming lives in one configuration shift register. It is loaded one bit per clock before use. The register of each macrocell has a selectable clear source and a selectable clock enable, and can be bypassed for a purely combinational output. The same output bit serves both the routing array and the pin path.

Top module: `cpld_lab`

## Requirements
- R1: While `cfg_en` is high, each rising edge shifts `cfg_din` in. After CFGW shifts, the first bit sent sits at bit 0. Macrocell m occupies bits m*MCW up to m*MCW+MCW-1, with MCW = 10*(NSIG+NMC)+5. Term p of that macrocell has its true-literal mask at offset p*2*NIN and its complement mask at offset p*2*NIN+NIN, where NIN = NSIG+NMC. Mask index i below NSIG selects `arr_in[i]`, and index NSIG+k selects pool slot k. The control bits sit at offset 10*NIN: +0 donate, +1 shared, +2 term clear, +3 enable select, +4 bypass.
- R2: A term is the AND of its selected literals. A term with no literal selected reads 0, and a term that selects both polarities of one input reads 0.
- R3: With bypass set, `mc_out` is the OR of the macrocell's kept terms and any borrowed terms, and it follows the inputs with no clock.
- R4: A receiver with donate clear collects the full sums of donors m+1 up to m+k, where every macrocell from m+1 to m+k has donate set and k is at most 3 (15 terms). A 12-term function spread over three macrocells is realised exactly.
- R5: A macrocell with donate set keeps none of its terms. Its own sum, and so its bypassed output, is 0.
- R6: A fourth consecutive donor does not reach the receiver.
- R7: With shared set, the AND of term 0's array literals is inverted into pool slot m. That term then leaves macrocell m's own OR. Any number of macrocells may read the slot.
- R8: A non-bypassed macrocell captures its sum on the rising clock edge. With enable select set, it captures only when `gce` is high; with it clear, it captures on every edge.
- R9: With term clear set, term 1 high clears the register at once, with no clock, and `gclr_n` has no effect on it.
- R10: With term clear clear, `gclr_n` low holds the register at 0 at once, so all such outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the configuration shift |
| gclr_n | input | 1 | Global asynchronous clear, active low |
| gce | input | 1 | Global clock enable for macrocells that select it |
| cfg_en | input | 1 | Shift enable for the configuration register |
| cfg_din | input | 1 | Serial configuration data |
| arr_in | input | NSIG | Array signals offered to every term |
| mc_out | output | NMC | Output of each macrocell |

## Verification
The bench sweeps the array inputs against one loaded image that holds every mode at once. A 12-term minterm function over three chained macrocells would lose values if any donor term were dropped. The bench checks that a fourth donor's term stays out, which a chain that did not stop would let through. It checks that shared-pool readers see an inverted OR and that the donor of the pool slot outputs 0; a missing inversion or a term left in the donor's OR would show here. The register tests hold and load under enable, apply a term clear with no clock edge while the global clear is ignored, and hold the global clear low; a swapped clear source or an edge-timed clear would show.

// File: rtl/cpld_lab.sv
module cpld_lab #(
  parameter int NMC  = 16,
  parameter int NSIG = 36,
  parameter int NPT  = 5,
  parameter int MAXG = 3
) (
  input  logic            clk,
  input  logic            gclr_n,
  input  logic            gce,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic [NSIG-1:0] arr_in,
  output logic [NMC-1:0]  mc_out
);
  localparam int NIN  = NSIG + NMC;
  localparam int PTW  = 2 * NIN;
  localparam int CTLB = NPT * PTW;
  localparam int MCW  = CTLB + 5;
  localparam int CFGW = NMC * MCW;

  logic [CFGW-1:0] cfg;
  logic [NIN-1:0]  lits;
  logic [NMC-1:0]  pool, own_or, sum, q;
  logic [NMC-1:0]  pass_dn, shr_en, clr_sel, ce_sel, byp, clr_n_int;

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg_din, cfg[CFGW-1:1]};

  assign lits = {pool, arr_in};

  for (genvar n = 0; n < NMC; n++) begin : g_mc
    localparam int B = n * MCW;
    logic [NPT-1:0]  pt, keep;
    logic [NSIG-1:0] sh_t, sh_c;
    logic            sh_pt, q_r;
    logic [MAXG:0]   grab;

    assign pass_dn[n] = cfg[B+CTLB];
    assign shr_en[n]  = cfg[B+CTLB+1];
    assign clr_sel[n] = cfg[B+CTLB+2];
    assign ce_sel[n]  = cfg[B+CTLB+3];
    assign byp[n]     = cfg[B+CTLB+4];

    for (genvar p = 0; p < NPT; p++) begin : g_pt
      logic [NIN-1:0] tm, cm;
      assign tm    = cfg[B+p*PTW +: NIN];
      assign cm    = cfg[B+p*PTW+NIN +: NIN];
      assign pt[p] = (|(tm | cm)) & (&(~tm | lits)) & (&(~cm | ~lits));
    end

    assign sh_t    = cfg[B +: NSIG];
    assign sh_c    = cfg[B+NIN +: NSIG];
    assign sh_pt   = (|(sh_t | sh_c)) & (&(~sh_t | arr_in)) & (&(~sh_c | ~arr_in));
    assign pool[n] = shr_en[n] & ~sh_pt;

    assign keep      = {{(NPT-2){1'b1}}, ~clr_sel[n], ~shr_en[n]};
    assign own_or[n] = |(pt & keep);

    assign grab[0] = 1'b0;
    for (genvar k = 1; k <= MAXG; k++) begin : g_chain
      if (n + k < NMC) begin : g_in
        assign grab[k] = grab[k-1] | ((&pass_dn[n+k:n+1]) & own_or[n+k]);
      end else begin : g_edge
        assign grab[k] = grab[k-1];
      end
    end

    assign sum[n]       = ~pass_dn[n] & (own_or[n] | grab[MAXG]);
    assign clr_n_int[n] = clr_sel[n] ? ~pt[1] : gclr_n;

    always_ff @(posedge clk or negedge clr_n_int[n])
      if (!clr_n_int[n])             q_r <= 1'b0;
      else if (!ce_sel[n] || gce)    q_r <= sum[n];

    assign q[n]      = q_r;
    assign mc_out[n] = byp[n] ? sum[n] : q[n];
  end
endmodule

module cpld_lab_chk #(parameter int NMC = 16) (
  input logic           clk,
  input logic           gclr_n,
  input logic           gce,
  input logic           cfg_en,
  input logic [NMC-1:0] pass_dn,
  input logic [NMC-1:0] byp,
  input logic [NMC-1:0] ce_sel,
  input logic [NMC-1:0] clr_sel,
  input logic [NMC-1:0] clr_n_int,
  input logic [NMC-1:0] sum,
  input logic [NMC-1:0] q,
  input logic [NMC-1:0] mc_out
);
  for (genvar n = 0; n < NMC; n++) begin : g_a
    a_r5_donor_silent: assert property (@(posedge clk) disable iff (!gclr_n)
      (!cfg_en && pass_dn[n] && byp[n]) |-> (mc_out[n] == 1'b0));

    a_r10_global_clear: assert property (@(posedge clk) disable iff (cfg_en)
      (!gclr_n && !clr_sel[n]) |-> (q[n] == 1'b0));

    a_r9_term_clear: assert property (@(posedge clk) disable iff (!gclr_n)
      (!cfg_en && clr_sel[n] && !clr_n_int[n]) |-> (q[n] == 1'b0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!gclr_n)
      (!cfg_en && ce_sel[n] && !gce && clr_n_int[n])
        |=> ((q[n] == $past(q[n])) || !clr_n_int[n]));

    a_r8_capture: assert property (@(posedge clk) disable iff (!gclr_n)
      (!cfg_en && $past(!cfg_en) && clr_n_int[n] && $past(clr_n_int[n])
        && $past(!ce_sel[n] || gce)) |-> (q[n] == $past(sum[n])));
  end
endmodule

bind cpld_lab cpld_lab_chk #(.NMC(NMC)) chk_i (
  .clk(clk), .gclr_n(gclr_n), .gce(gce), .cfg_en(cfg_en),
  .pass_dn(pass_dn), .byp(byp), .ce_sel(ce_sel), .clr_sel(clr_sel),
  .clr_n_int(clr_n_int), .sum(sum), .q(q), .mc_out(mc_out)
);

// File: tb/cpld_lab_tb_top.sv
`timescale 1ns/1ps
module cpld_lab_tb_top;
  localparam int NMC  = 16;
  localparam int NSIG = 36;
  localparam int NPT  = 5;
  localparam int NIN  = NSIG + NMC;
  localparam int PTW  = 2 * NIN;
  localparam int CTLB = NPT * PTW;
  localparam int MCW  = CTLB + 5;
  localparam int CFGW = NMC * MCW;
  localparam int C_DON = 0, C_SHR = 1, C_CLR = 2, C_CE = 3, C_BYP = 4;

  logic clk = 1'b0;
  logic gclr_n = 1'b0, gce = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
  logic [NSIG-1:0] arr_in = '0;
  logic [NMC-1:0]  mc_out;
  logic [CFGW-1:0] img = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpld_lab dut_i (.clk(clk), .gclr_n(gclr_n), .gce(gce), .cfg_en(cfg_en),
                  .cfg_din(cfg_din), .arr_in(arr_in), .mc_out(mc_out));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic lit(input int mc, input int p, input int idx, input bit comp);
    img[mc*MCW + p*PTW + (comp ? NIN : 0) + idx] = 1'b1;
  endtask

  task automatic ctl(input int mc, input int b);
    img[mc*MCW + CTLB + b] = 1'b1;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R4: minterms 0..11 of arr_in[3:0] over mc0 (receiver), mc1 and mc2 (donors)
    for (int v = 0; v < 12; v++)
      for (int b = 0; b < 4; b++) lit(v / 5, v % 5, b, ((v >> b) & 1) == 0);
    ctl(0, C_BYP); ctl(1, C_DON); ctl(1, C_BYP); ctl(2, C_DON); ctl(2, C_BYP);
    // R6: mc4 receives from mc5..mc7, mc8 is a fourth donor
    for (int d = 0; d < 4; d++) begin
      lit(5 + d, 0, d, 1'b0); ctl(5 + d, C_DON); ctl(5 + d, C_BYP);
    end
    ctl(4, C_BYP);
    // R2: mc9 empty terms plus a contradictory term
    lit(9, 3, 4, 1'b0); lit(9, 3, 4, 1'b1); ctl(9, C_BYP);
    // R7: mc10 places ~(~a4 & ~a5) in pool slot 10
    lit(10, 0, 4, 1'b1); lit(10, 0, 5, 1'b1); ctl(10, C_SHR); ctl(10, C_BYP);
    lit(11, 0, NSIG + 10, 1'b0); lit(11, 0, 6, 1'b0); ctl(11, C_BYP);
    lit(12, 2, NSIG + 10, 1'b0); ctl(12, C_BYP);
    // R8: mc13 registered a7 with enable select
    lit(13, 0, 7, 1'b0); ctl(13, C_CE);
    // R9: mc14 registered a9, term clear from a8
    lit(14, 0, 9, 1'b0); lit(14, 1, 8, 1'b0); ctl(14, C_CLR);

    tick;
    for (int i = 0; i < CFGW; i++) begin
      cfg_din = img[i]; cfg_en = 1'b1; tick;
    end
    cfg_en = 1'b0; cfg_din = 1'b0;
    tick; #1;
    chk(mc_out[13], 1'b0, "R10 reset mc13");
    chk(mc_out[15], 1'b0, "R10 reset mc15");
    chk(mc_out[3],  1'b0, "R10 reset mc3");
    gclr_n = 1'b1; tick;

    for (int v = 0; v < 128; v++) begin
      arr_in[6:0] = 7'(v);
      #1;
      chk(mc_out[0], (v & 15) < 12, "R4 twelve-term receiver");
      chk(mc_out[1] | mc_out[2], 1'b0, "R5 donors silent");
      chk(mc_out[4], ((v & 7) != 0), "R6 three donors reach receiver");
      chk(mc_out[8] | mc_out[5], 1'b0, "R5 outer donors silent");
      chk(mc_out[9], 1'b0, "R2 empty and contradictory terms");
      chk(mc_out[10], 1'b0, "R7 shared term leaves own OR");
      chk(mc_out[11], ((v >> 6) & 1) & (((v >> 4) & 3) != 0), "R7 pool reader A");
      chk(mc_out[12], ((v >> 4) & 3) != 0, "R7 pool reader B");
      chk(mc_out[3], 1'b0, "R3 unconfigured stays low");
      #1;
    end
    arr_in = '0; tick;

    // R8 enable select
    arr_in[7] = 1'b1; gce = 1'b0; tick; #1;
    chk(mc_out[13], 1'b0, "R8 held with gce low");
    gce = 1'b1; tick; #1;
    chk(mc_out[13], 1'b1, "R8 capture with gce high");
    arr_in[7] = 1'b0; gce = 1'b0; tick; #1;
    chk(mc_out[13], 1'b1, "R8 hold keeps one");
    gce = 1'b1; tick; #1;
    chk(mc_out[13], 1'b0, "R8 capture zero");
    arr_in[7] = 1'b1; tick; #1;
    chk(mc_out[13], 1'b1, "R8 reload one");

    // R9 term clear on mc14, global clear ignored there
    arr_in[9] = 1'b1; tick; #1;
    chk(mc_out[14], 1'b1, "R9 mc14 loads");
    gclr_n = 1'b0; #1;
    chk(mc_out[13], 1'b0, "R10 global clear without clock");
    chk(mc_out[14], 1'b1, "R9 global clear ignored");
    tick; #1;
    chk(mc_out[14], 1'b1, "R9 global clear ignored across edge");
    gclr_n = 1'b1; tick;
    arr_in[8] = 1'b1; #1;
    chk(mc_out[14], 1'b0, "R9 term clear without clock");
    tick; #1;
    chk(mc_out[14], 1'b0, "R9 term clear holds across edge");
    arr_in[8] = 1'b0; tick; #1;
    chk(mc_out[14], 1'b1, "R9 release and reload");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule